// File: doc/BRIEF.md
# Reloading Down-Counter Interrupt Timer

This block is a programmable down-counter behind a small word-addressed register interface. Software writes a start value into a load register and sets the control bits. Once enabled, the counter drops by one on each pulse of the chosen tick input. When a tick arrives while the counter already reads zero, the block raises a level interrupt. The counter then either takes the load value again (periodic mode) or rolls over to its all-ones value (free-wrap mode).

The counter width is a parameter, so one description covers both narrow and wide instances. Two tick-enable inputs come from outside at two different rates, and a control bit chooses which one paces the counter. The interrupt stays high until software writes any value to the clear register.

Top module: `dntmr_top`

## Requirements
- R1: After synchronous reset, the load register, counter, control bits, `irq` and `bus_rdata` are all zero.
- R2: Registers are selected by `bus_addr[3:2]` when `bus_addr[1:0]` is zero. The map is: 0 = load (read/write), 1 = counter value (read-only), 2 = control, 3 = clear (write-only, reads zero). In the control register, bit 7 is enable, bit 6 is periodic mode and bit 3 is fast-tick select, and every other bit reads back 0. A read request in one cycle puts the register contents from before that clock edge on `bus_rdata` in the next cycle.
- R3: In periodic mode (bit 6 = 1), an enabled tick that arrives while the counter is zero loads the counter from the load register.
- R4: An enabled tick that arrives while the counter is zero sets `irq` in the next cycle. `irq` then stays high until it is cleared.
- R5: A write of any data to the clear register drops `irq` in the next cycle. If an underflow happens in the same cycle, the underflow wins and `irq` stays high.
- R6: With bit 3 = 1 only `tick_fast` advances the counter, and with bit 3 = 0 only `tick_slow` does. The unselected tick input has no effect.
- R7: While enable is low, the counter holds its value and `irq` does not rise. Writing 0 to the control register stops the timer.
- R8: In free-wrap mode (bit 6 = 0), an enabled tick that arrives while the counter is zero sets the counter to all ones at the counter width.
- R9: A load-register write while enabled also puts the written value into the counter at the same edge. While disabled, such a write changes only the load register.
- R10: A control write that sets enable while enable is low copies the load register into the counter.
- R11: Writes to the counter-value register have no effect.
- R12: When a load write and an enabled tick fall in the same cycle, the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read request, one cycle per read |
| bus_addr | input | ADDR_W | Byte address within the timer |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tick_slow | input | 1 | Slow-rate count enable pulse |
| tick_fast | input | 1 | Fast-rate count enable pulse |
| irq | output | 1 | Level interrupt, high while an underflow is pending |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the interrupt clear and the underflow that sets the interrupt. The bench first counts the timer down to zero. It then drives a clear write together with the selected tick in one cycle and requires `irq` to stay high, with the counter reloaded. The second pair is a load write and a count tick. The bench issues both in the same cycle and requires the counter to read back the written value rather than that value minus one.

// File: rtl/dntmr_pkg.sv
package dntmr_pkg;

  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef enum logic [1:0] {
    IDX_LOAD  = 2'd0,
    IDX_VALUE = 2'd1,
    IDX_CTRL  = 2'd2,
    IDX_CLEAR = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic en;
    logic per;
    logic fast;
  } ctrl_t;

  function automatic logic [7:0] ctrl_pack(input ctrl_t c);
    logic [7:0] v;
    v = '0;
    v[BIT_EN]   = c.en;
    v[BIT_PER]  = c.per;
    v[BIT_FAST] = c.fast;
    return v;
  endfunction

endpackage

// File: rtl/dntmr_regs.sv
module dntmr_regs
  import dntmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [CNT_W-1:0]  load_q,
  output ctrl_t             ctrl_q,
  output logic              ld_wr,
  output logic              clr_wr,
  output logic              start
);

  logic     aligned;
  reg_idx_e idx;
  logic     ctrl_wr;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign idx     = reg_idx_e'(bus_addr[3:2]);
  assign ld_wr   = bus_wr && aligned && (idx == IDX_LOAD);
  assign ctrl_wr = bus_wr && aligned && (idx == IDX_CTRL);
  assign clr_wr  = bus_wr && aligned && (idx == IDX_CLEAR);
  assign start   = ctrl_wr && bus_wdata[BIT_EN] && !ctrl_q.en;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (ld_wr) load_q <= bus_wdata[CNT_W-1:0];
      if (ctrl_wr) begin
        ctrl_q.en   <= bus_wdata[BIT_EN];
        ctrl_q.per  <= bus_wdata[BIT_PER];
        ctrl_q.fast <= bus_wdata[BIT_FAST];
      end
    end
  end

  AST_ZERO_CTRL_STOPS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && bus_wdata == '0) |=> !ctrl_q.en); // R7

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    ld_wr |=> (load_q == $past(bus_wdata[CNT_W-1:0]))); // R9

endmodule

// File: rtl/dntmr_core.sv
module dntmr_core
  import dntmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrl_t            ctrl_q,
  input  logic [CNT_W-1:0] load_q,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             ld_wr,
  input  logic             clr_wr,
  input  logic             start,
  input  logic             tick_slow,
  input  logic             tick_fast,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic tick;
  logic step;
  logic at_zero;
  logic undf;
  logic ld_now;

  assign tick    = ctrl_q.fast ? tick_fast : tick_slow;
  assign ld_now  = ld_wr && ctrl_q.en;
  assign step    = ctrl_q.en && tick && !ld_now;
  assign at_zero = (cnt_q == '0);
  assign undf    = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld_now) begin
      cnt_q <= ld_data;
    end else if (start) begin
      cnt_q <= load_q;
    end else if (step) begin
      if (at_zero) cnt_q <= ctrl_q.per ? load_q : ALL_ONES;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         irq_q <= 1'b0;
    else if (undf)   irq_q <= 1'b1;
    else if (clr_wr) irq_q <= 1'b0;
  end

  AST_UNDERFLOW_SETS: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.en && tick && at_zero && !ld_wr) |=> irq_q); // R4

  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !(ctrl_q.en && tick && at_zero && !ld_wr)) |=> !irq_q); // R5

  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.en && ctrl_q.per && tick && at_zero && !ld_wr) |=> (cnt_q == $past(load_q))); // R3

  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.en && !ctrl_q.per && tick && at_zero && !ld_wr) |=> (cnt_q == ALL_ONES)); // R8

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !start) |=> $stable(cnt_q)); // R7

  AST_NO_IRQ_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.en && !irq_q) |=> !irq_q); // R7

  AST_LOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (rst)
    (ld_wr && ctrl_q.en) |=> (cnt_q == $past(ld_data))); // R12

endmodule

// File: rtl/dntmr_rdmux.sv
module dntmr_rdmux
  import dntmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  load_q,
  input  logic [CNT_W-1:0]  cnt_q,
  input  ctrl_t             ctrl_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic [DATA_W-1:0] load_x;
  logic [DATA_W-1:0] cnt_x;
  logic [DATA_W-1:0] ctrl_x;
  logic              rd_hit;
  reg_idx_e          idx;

  generate
    if (CNT_W == DATA_W) begin : g_full
      assign load_x = load_q;
      assign cnt_x  = cnt_q;
    end else begin : g_pad
      assign load_x = {{(DATA_W-CNT_W){1'b0}}, load_q};
      assign cnt_x  = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
    end
  endgenerate

  assign ctrl_x = {{(DATA_W-8){1'b0}}, ctrl_pack(ctrl_q)};
  assign rd_hit = bus_rd && (bus_addr[1:0] == 2'b00);
  assign idx    = reg_idx_e'(bus_addr[3:2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_hit) begin
      case (idx)
        IDX_LOAD:  rdata_q <= load_x;
        IDX_VALUE: rdata_q <= cnt_x;
        IDX_CTRL:  rdata_q <= ctrl_x;
        default:   rdata_q <= '0;
      endcase
    end
  end

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 4'hC) |=> (rdata_q == '0)); // R2

endmodule

// File: rtl/dntmr_top.sv
module dntmr_top
  import dntmr_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_slow,
  input  logic              tick_fast,
  output logic              irq
);

  logic [CNT_W-1:0] load_q;
  logic [CNT_W-1:0] cnt_q;
  ctrl_t            ctrl_q;
  logic             ld_wr;
  logic             clr_wr;
  logic             start;

  dntmr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .load_q(load_q), .ctrl_q(ctrl_q),
    .ld_wr(ld_wr), .clr_wr(clr_wr), .start(start)
  );

  dntmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .ctrl_q(ctrl_q), .load_q(load_q),
    .ld_data(bus_wdata[CNT_W-1:0]), .ld_wr(ld_wr), .clr_wr(clr_wr),
    .start(start), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .cnt_q(cnt_q), .irq_q(irq)
  );

  dntmr_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdmux (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .load_q(load_q), .cnt_q(cnt_q), .ctrl_q(ctrl_q), .rdata_q(bus_rdata)
  );

endmodule

// File: tb/dntmr_top_tb_top.sv
module dntmr_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dntmr_top #(.ADDR_W(4), .DATA_W(32), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .irq(irq)
  );

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: pops expected read data one cycle after each request
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: read data %h with no expectation", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic op(input logic w, input logic [3:0] a, input logic [31:0] d,
                    input logic tf, input logic ts);
    bus_wr = w; bus_addr = a; bus_wdata = d; tick_fast = tf; tick_slow = ts;
    @(negedge clk);
    bus_wr = 1'b0; tick_fast = 1'b0; tick_slow = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    op(1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic ticks(input logic tf, input logic ts, input int n);
    for (int i = 0; i < n; i++) op(1'b0, 4'h0, 32'h0, tf, ts);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  bit done = 0;

  initial begin
    #2000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(4'h0, 32'h0, "R1 load after reset");
    rd(4'h4, 32'h0, "R1 count after reset");
    rd(4'h8, 32'h0, "R1 ctrl after reset");

    // R9 disabled load write leaves counter
    wr(4'h0, 32'h0000_0003);
    rd(4'h0, 32'h3, "R9 load readback");
    rd(4'h4, 32'h0, "R9 counter untouched while off");
    // R11 value register is read-only
    wr(4'h4, 32'h55);
    rd(4'h4, 32'h0, "R11 write to value ignored");
    // R10 enable copies load; R2 control bits sparse
    wr(4'h8, 32'hFF);
    rd(4'h8, 32'hC8, "R2 control readback");
    rd(4'h4, 32'h3, "R10 start copies load");

    // R6 slow tick ignored while fast selected
    ticks(1'b0, 1'b1, 2);
    rd(4'h4, 32'h3, "R6 unselected slow tick");
    ticks(1'b1, 1'b0, 3);
    rd(4'h4, 32'h0, "R6 fast tick counts down");
    chk_irq(1'b0, "R4 no irq before underflow");
    ticks(1'b1, 1'b0, 1);
    chk_irq(1'b1, "R4 irq on underflow");
    rd(4'h4, 32'h3, "R3 periodic reload");
    rd(4'hC, 32'h0, "R2 clear reads zero");
    chk_irq(1'b1, "R4 irq held");
    wr(4'hC, 32'hDEAD);
    chk_irq(1'b0, "R5 clear drops irq");

    // R5 clear and underflow in the same cycle
    ticks(1'b1, 1'b0, 3);
    op(1'b1, 4'hC, 32'h0, 1'b1, 1'b0);
    chk_irq(1'b1, "R5 underflow beats clear");
    rd(4'h4, 32'h3, "R3 reload at collision");
    wr(4'hC, 32'h1);
    chk_irq(1'b0, "R5 later clear");

    // R8 free wrap, slow tick
    wr(4'h8, 32'h80);
    rd(4'h4, 32'h3, "R10 no copy when already enabled");
    ticks(1'b1, 1'b0, 2);
    rd(4'h4, 32'h3, "R6 unselected fast tick");
    ticks(1'b0, 1'b1, 3);
    chk_irq(1'b0, "R4 not yet");
    ticks(1'b0, 1'b1, 1);
    chk_irq(1'b1, "R8 irq on wrap");
    rd(4'h4, 32'h0000_FFFF, "R8 wraps to all ones");
    wr(4'hC, 32'h0);
    chk_irq(1'b0, "R5 clear after wrap");

    // R9 load while enabled, R12 load beats tick
    wr(4'h0, 32'h10);
    rd(4'h4, 32'h10, "R9 enabled load copies");
    op(1'b1, 4'h0, 32'h20, 1'b0, 1'b1);
    rd(4'h4, 32'h20, "R12 load beats tick");
    rd(4'h0, 32'h20, "R12 load register");

    // R7 stopped timer holds
    wr(4'h8, 32'h0);
    ticks(1'b1, 1'b1, 5);
    rd(4'h4, 32'h20, "R7 counter held");
    rd(4'h8, 32'h0, "R7 control zero");
    wr(4'h0, 32'h7);
    rd(4'h4, 32'h20, "R9 disabled load keeps counter");
    wr(4'h8, 32'h88);
    rd(4'h4, 32'h7, "R10 start copies new load");
    ticks(1'b1, 1'b0, 7);
    rd(4'h4, 32'h0, "R7 reached zero");
    wr(4'h8, 32'h0);
    ticks(1'b1, 1'b1, 3);
    chk_irq(1'b0, "R7 no irq while off");
    rd(4'h4, 32'h0, "R7 zero held while off");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule